// File: doc/BRIEF.md
# Three-Channel Time-Window Voltage Averager

This block takes 12-bit results from three voltage-sense converter channels and computes a boxcar mean for each one. Each channel marks a new sample with a one-cycle valid strobe. Samples arrive at a low and slightly irregular rate compared with the system clock. A free-running cycle counter divides time into windows of fixed length, 10 ms by default. During a window the block adds up every strobed sample and counts how many arrived, separately for each channel.

On the last cycle of a window, each channel's sum is divided by that channel's own sample tally. The quotient is written into a held average register, and the sum and the tally then restart from zero. A host reads the three held averages through a plain address/data read port at consecutive addresses. The value it gets stays the same until the next window ends. A host that polls at least once per window therefore always sees a true mean over the most recent complete window.

Top module: `vsense_window_avg`

## Requirements
- R1: Window ends occur every WIN_CYCLES clock edges counted from reset release, with the first at edge WIN_CYCLES, and the held averages change only at those edges.
- R2: Every sample whose valid strobe is high inside a window is added to that window's sum and tally, including samples strobed on the window's first and last cycles.
- R3: With MAX_SAMPLES samples of full-scale value 4095 in one window, the result is exactly 4095, because the sum and tally never overflow.
- R4: Each loaded average equals floor(sum / tally), where the tally is the actual number of samples that channel received in that window.
- R5: Between window ends, each held average stays constant whatever the inputs do.
- R6: Read address 0x15 returns channel 0, 0x16 returns channel 1 and 0x17 returns channel 2. Any other address returns zero.
- R7: rd_data_o is registered, giving one cycle of read latency. A read captured on the same edge as a window-end load returns the newly loaded value.
- R8: After reset, every average reads zero until the first window ends.
- R9: A channel that receives no samples in a window keeps its previous average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | NUM_CH | Per-channel sample strobe, one cycle per sample |
| smp_data_i | input | NUM_CH*DATA_W | Packed samples, channel c in bits [c*DATA_W +: DATA_W] |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Registered read data |

## Verification
The bench runs the averager with several stimulus patterns, one pattern per window.

- **Constant full-rate samples:** separate the averaging path from the address decode.
- **Sparse strobes at different periods per channel, with ramped data:** show whether the divisor is the real tally rather than a fixed count.
- **A channel driven with alternating 0 and 4095:** exposes wrong rounding.
- **Windows with a single sample on the first or last cycle:** catch an off-by-one at the window boundary.
- **Windows with no samples:** show that the old value is held.
- **A full-scale, full-rate window:** catches an accumulator that is too narrow.

Reads placed just before and just after each window-end edge, together with an unmapped address, pin down the load timing and the read-mux bypass.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  localparam int SAMPLE_W      = 12;
  localparam int RD_ADDR_W     = 8;
  localparam int AVG_BASE_ADDR = 'h15;
  localparam int CHANNELS      = 3;
endpackage

// File: rtl/vsa_window_timer.sv
module vsa_window_timer #(
  parameter int WIN_CYCLES = 500000,
  localparam int CW = $clog2(WIN_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_end_o
);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign win_end_o = (cnt_q == LAST);

  assert_count_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  if (WIN_CYCLES > 1) begin : g_period
    assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_end_o |=> !win_end_o);
  end
endmodule

// File: rtl/vsa_chan_acc.sv
module vsa_chan_acc #(
  parameter int DATA_W      = 12,
  parameter int MAX_SAMPLES = 16384,
  localparam int CNT_W = $clog2(MAX_SAMPLES + 1),
  localparam int SUM_W = DATA_W + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_end_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic [DATA_W-1:0] avg_o,
  output logic [DATA_W-1:0] avg_next_o,
  output logic              load_o
);
  logic [SUM_W-1:0]  sum_q, sum_next, quo;
  logic [CNT_W-1:0]  cnt_q, cnt_next;
  logic [DATA_W-1:0] avg_q;

  // the sample strobed on the last cycle still belongs to the closing window
  assign sum_next   = sum_q + (smp_valid_i ? SUM_W'(smp_data_i) : '0);
  assign cnt_next   = cnt_q + CNT_W'(smp_valid_i);
  assign quo        = (cnt_next == '0) ? '0 : sum_next / SUM_W'(cnt_next);
  assign load_o     = win_end_i && (cnt_next != '0);
  assign avg_next_o = quo[DATA_W-1:0];
  assign avg_o      = avg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
      avg_q <= '0;
    end else if (win_end_i) begin
      sum_q <= '0;
      cnt_q <= '0;
      if (load_o) avg_q <= avg_next_o;
    end else begin
      sum_q <= sum_next;
      cnt_q <= cnt_next;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_SAMPLES));

  assert_mean_fits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (quo[SUM_W-1:DATA_W] == '0));

  assert_hold_between_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(avg_q));

  assert_empty_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_i && !load_o) |=> $stable(avg_q));
endmodule

// File: rtl/vsa_read_port.sv
module vsa_read_port #(
  parameter int NUM_CH    = 3,
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH*DATA_W-1:0] avg_cur_i,
  input  logic [NUM_CH*DATA_W-1:0] avg_new_i,
  input  logic [NUM_CH-1:0]        load_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_ADDR + NUM_CH);

  logic [DATA_W-1:0] sel, rd_q;

  always_comb begin
    sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr_i == ADDR_W'(BASE_ADDR + c))
        sel = load_i[c] ? avg_new_i[c*DATA_W +: DATA_W] : avg_cur_i[c*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= sel;
  end

  assign rd_data_o = rd_q;

  assert_unmapped_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i < LO || rd_addr_i >= HI) |=> (rd_data_o == '0));
endmodule

// File: rtl/vsense_window_avg.sv
module vsense_window_avg
  import vsa_pkg::*;
#(
  parameter int NUM_CH      = CHANNELS,
  parameter int DATA_W      = SAMPLE_W,
  parameter int ADDR_W      = RD_ADDR_W,
  parameter int BASE_ADDR   = AVG_BASE_ADDR,
  parameter int WIN_CYCLES  = 500000,
  parameter int MAX_SAMPLES = 16384
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        smp_valid_i,
  input  logic [NUM_CH*DATA_W-1:0] smp_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  logic                     win_end;
  logic [NUM_CH*DATA_W-1:0] avg_cur, avg_new;
  logic [NUM_CH-1:0]        load;

  vsa_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_end_o(win_end)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vsa_chan_acc #(.DATA_W(DATA_W), .MAX_SAMPLES(MAX_SAMPLES)) u_acc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .win_end_i  (win_end),
      .smp_valid_i(smp_valid_i[c]),
      .smp_data_i (smp_data_i[c*DATA_W +: DATA_W]),
      .avg_o      (avg_cur[c*DATA_W +: DATA_W]),
      .avg_next_o (avg_new[c*DATA_W +: DATA_W]),
      .load_o     (load[c])
    );
  end

  vsa_read_port #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .avg_cur_i(avg_cur),
    .avg_new_i(avg_new),
    .load_i   (load),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: tb/vsense_window_avg_test.sv
module vsense_window_avg_test;
  localparam int WIN = 40;
  localparam int NW  = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  smp_valid = '0;
  logic [35:0] smp_data = '0;
  logic [7:0]  rd_addr = 8'h15;
  logic [11:0] rd_data;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [35:0] expq[$];
  logic [35:0] cur = '0;

  always #10 clk = ~clk;

  vsense_window_avg #(.WIN_CYCLES(WIN), .MAX_SAMPLES(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s cyc=%0d act=%0d exp=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] hsh(input int a);
    logic [31:0] x = a * 32'h9E3779B1;
    return x ^ (x >> 13);
  endfunction

  task automatic pattern(input int w, input int j, input int c,
                         output logic v, output logic [11:0] d);
    logic [31:0] h;
    v = 0; d = '0;
    case (w)
      0: begin v = 1; d = (c == 0) ? 12'd100 : (c == 1) ? 12'd2000 : 12'd4095; end
      1: case (c)
           0: begin v = (j % 3 == 0); d = 12'(j * 50); end
           1: begin v = (j % 7 == 0); d = 12'(4095 - j * 10); end
           default: begin v = 1; d = (j % 2) ? 12'd4095 : 12'd0; end
         endcase
      2: case (c)
           0: v = 0;
           1: begin v = (j == WIN - 1); d = 12'd1234; end
           default: begin v = (j == 0); d = 12'd3; end
         endcase
      3, 5: begin h = hsh(w * 1000 + j * 8 + c); v = (h[3:0] > 4'd4); d = h[27:16]; end
      4: begin v = 1; d = 12'd4095; end
      default: v = 0;
    endcase
  endtask

  // driver: stimulus plus expected averages pushed to the scoreboard
  initial begin
    logic [35:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    prev = '0;
    for (int w = 0; w < NW; w++) begin
      int sum[3];
      int cnt[3];
      for (int c = 0; c < 3; c++) begin sum[c] = 0; cnt[c] = 0; end
      for (int j = 0; j < WIN; j++) begin
        if (j != 0) @(negedge clk);
        for (int c = 0; c < 3; c++) begin
          logic v; logic [11:0] d;
          pattern(w, j, c, v, d);
          smp_valid[c] = v;
          smp_data[c*12 +: 12] = v ? d : 12'(hsh(j + c));
          if (v) begin sum[c] += int'(d); cnt[c]++; end
        end
      end
      for (int c = 0; c < 3; c++)
        if (cnt[c] != 0) prev[c*12 +: 12] = 12'(sum[c] / cnt[c]);
      expq.push_back(prev);
      @(negedge clk);
    end
    smp_valid = '0;
    repeat (WIN / 2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  // monitor: pops expected averages at each window end and compares reads
  always @(negedge clk) begin
    if (rst_n) begin
      int t, wi;
      string tg;
      t  = cyc % WIN;
      wi = cyc / WIN - 1;
      if (t == 0 && cyc > 0 && expq.size() > 0) cur = expq.pop_front();
      if (cyc < WIN)                  tg = "R8";
      else if (wi == 4)               tg = "R3";
      else if (wi == 1 || wi == 2)    tg = "R2";
      else if (wi >= 6)               tg = "R9";
      else                            tg = "R4";
      if (wi == 2 && t == 1) tg = "R9";
      case (t)
        0: begin
          if (cyc > 0) chk((cyc < WIN) ? "R8" : "R7", rd_data, cur[11:0]);
          rd_addr = 8'h16;
        end
        1: begin chk(tg, rd_data, cur[23:12]); rd_addr = 8'h17; end
        2: begin chk(tg, rd_data, cur[35:24]); rd_addr = 8'h20; end
        3: begin chk("R6", rd_data, 12'd0);    rd_addr = 8'h15; end
        WIN / 2: chk((cyc < WIN) ? "R8" : "R5", rd_data, cur[11:0]);
        WIN - 1: chk((cyc < WIN) ? "R8" : "R1", rd_data, cur[11:0]);
        default: ;
      endcase
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule